// File: doc/BRIEF.md
# Endian-Selectable I2C Word/Byte Packer

This block sits between a 16-bit data FIFO interface and the byte port of an I2C shift engine. In the transmit direction it takes the word at the head of a show-ahead write FIFO and gives the engine its two bytes one at a time. The FIFO entry is popped only after the second byte has been taken. In the receive direction it collects bytes from the engine into a word. It pushes each finished word into a read FIFO through a one-entry output register. Both byte ports and both word ports use valid/ready handshakes.

A configuration bit sets which half of a word is on the wire first. The same bit sets where the first and second received bytes are placed. The block copies this bit only when the engine reports a START or repeated START, so changing it during a transfer has no effect until the next one. If a transfer ends with half a word received, that half word is pushed with the other half zero. If the engine asks for a byte while the write FIFO is empty, the block raises a sticky underrun flag instead of sending anything.

Top module: `i2c_byte_packer`

## Requirements
- R1: After reset `tx_underrun` and `rxw_valid` are 0, and the byte order in use is little-endian, even when `cfg_msb_first` is 1, until the first `xfer_start` pulse.
- R2: With the sampled order little-endian (0), the first byte sent for a word is bits [7:0] and the second is bits [15:8].
- R3: With the sampled order big-endian (1), the first byte sent for a word is bits [15:8] and the second is bits [7:0].
- R4: With the sampled order little-endian, the 1st, 3rd, 5th… received byte of a transfer goes to bits [7:0] of its word and the 2nd, 4th… goes to bits [15:8].
- R5: With the sampled order big-endian, odd-numbered received bytes go to bits [15:8] and even-numbered bytes go to bits [7:0].
- R6: `cfg_msb_first` is sampled only in a cycle with `xfer_start` high. A change at any other time does not alter byte order until the next `xfer_start`.
- R7: `txw_ready` is high only in the cycle in which the second byte of the head word is accepted (`txb_valid && txb_ready`), or in a flush per R12. A word therefore gives exactly two byte transfers.
- R8: An `xfer_stop` pulse after an odd number of received bytes pushes the partial word, with the unused half set to zero, once the output register is free.
- R9: `xfer_start` resets the byte position on both paths to "first byte". A received byte that has no partner and is followed by a START without a STOP is dropped.
- R10: A cycle with `txb_ready` high while `txw_valid` is low keeps `txb_valid` low and sets `tx_underrun`. The flag stays set until the next `xfer_start` clears it.
- R11: While `rxw_valid` is high and `rxw_ready` is low, `rxw_word` holds steady and `rxb_ready` is low.
- R12: An `xfer_stop` pulse after only the first byte of a word has been sent pops that word, so the next word again starts with its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_msb_first | input | 1 | Byte order request: 0 little-endian, 1 big-endian |
| xfer_start | input | 1 | Pulse on START or repeated START |
| xfer_stop | input | 1 | Pulse at end of transfer (STOP or lost arbitration) |
| txw_word | input | 16 | Head word of the write FIFO |
| txw_valid | input | 1 | Write FIFO not empty |
| txw_ready | output | 1 | Pop the write FIFO |
| txb_data | output | 8 | Byte for the shift engine |
| txb_valid | output | 1 | Byte available |
| txb_ready | input | 1 | Engine takes / requests a byte |
| tx_underrun | output | 1 | Sticky: byte requested with write FIFO empty |
| rxb_data | input | 8 | Byte from the shift engine |
| rxb_valid | input | 1 | Received byte available |
| rxb_ready | output | 1 | Packer accepts the byte |
| rxw_word | output | 16 | Word for the read FIFO |
| rxw_valid | output | 1 | Word available |
| rxw_ready | input | 1 | Read FIFO accepts the word |

## Verification
A wrong byte position counter shows up at the very next byte. On transmit the swapped half appears on `txb_data`, and `txw_ready` fires a byte too early or too late. On receive the next pushed word has its halves exchanged. A wrong copy of the order bit reverses every word in the transfer, starting with the first byte after the START. A lost partial byte or a bad flush shows in the single word that follows `xfer_stop`, one cycle after the output register is free. A flag that clears itself, or a broken hold on `rxw_word`, shows within one cycle of the event.

// File: rtl/i2c_pack_pkg.sv
package i2c_pack_pkg;
   typedef enum logic {
      ORDER_LITTLE = 1'b0,
      ORDER_BIG    = 1'b1
   } byte_order_e;

   function automatic int unsigned lane_of(input int unsigned pos,
                                           input int unsigned lanes,
                                           input byte_order_e ord);
      return (ord == ORDER_BIG) ? (lanes - 1 - pos) : pos;
   endfunction
endpackage

// File: rtl/ipk_order_latch.sv
module ipk_order_latch
   import i2c_pack_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_msb_first,
   input  logic        xfer_start,
   output byte_order_e order_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          order_q <= ORDER_LITTLE;
      else if (xfer_start) order_q <= byte_order_e'(cfg_msb_first);
   end

   AST_ORDER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_start |=> $stable(order_q)); // R6
endmodule

// File: rtl/ipk_tx_split.sv
module ipk_tx_split
   import i2c_pack_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 2,
   localparam int WORD_W = BYTE_W * LANES,
   localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  byte_order_e       order_q,
   input  logic              xfer_start,
   input  logic              xfer_stop,
   input  logic [WORD_W-1:0] txw_word,
   input  logic              txw_valid,
   output logic              txw_ready,
   output logic [BYTE_W-1:0] txb_data,
   output logic              txb_valid,
   input  logic              txb_ready,
   output logic              tx_underrun
);
   localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(LANES - 1);

   logic [IDX_W-1:0]  pos_q;
   logic [IDX_W-1:0]  lane_sel;
   logic [BYTE_W-1:0] lane_b [LANES];
   logic              at_last, in_word, take;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_b[g] = txw_word[g*BYTE_W +: BYTE_W];
   end

   assign lane_sel  = IDX_W'(lane_of(int'(pos_q), LANES, order_q));
   assign txb_data  = lane_b[lane_sel];
   assign txb_valid = txw_valid;
   assign take      = txb_valid & txb_ready;
   assign at_last   = (pos_q == LAST_POS);
   assign in_word   = (pos_q != '0);
   assign txw_ready = txw_valid & ((txb_ready & at_last) | (xfer_stop & in_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pos_q <= '0;
      else if (xfer_start | xfer_stop) pos_q <= '0;
      else if (take)                  pos_q <= at_last ? '0 : pos_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       tx_underrun <= 1'b0;
      else if (xfer_start)              tx_underrun <= 1'b0;
      else if (txb_ready & !txw_valid)  tx_underrun <= 1'b1;
   end

   AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun && !xfer_start |=> tx_underrun); // R10
   AST_POP_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      txw_ready |-> (txb_valid && (txb_ready || xfer_stop))); // R7
endmodule

// File: rtl/ipk_rx_merge.sv
module ipk_rx_merge
   import i2c_pack_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 2,
   localparam int WORD_W = BYTE_W * LANES,
   localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  byte_order_e       order_q,
   input  logic              xfer_start,
   input  logic              xfer_stop,
   input  logic [BYTE_W-1:0] rxb_data,
   input  logic              rxb_valid,
   output logic              rxb_ready,
   output logic [WORD_W-1:0] rxw_word,
   output logic              rxw_valid,
   input  logic              rxw_ready
);
   localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(LANES - 1);

   logic [IDX_W-1:0]  pos_q;
   logic [IDX_W-1:0]  lane_sel;
   logic [WORD_W-1:0] part_q, placed, merged;
   logic              flush_pend_q, slot_free, accept, do_flush, at_last;

   assign slot_free = !rxw_valid | rxw_ready;
   assign rxb_ready = slot_free & !flush_pend_q;
   assign accept    = rxb_valid & rxb_ready;
   assign do_flush  = flush_pend_q & slot_free;
   assign at_last   = (pos_q == LAST_POS);
   assign lane_sel  = IDX_W'(lane_of(int'(pos_q), LANES, order_q));
   assign placed    = WORD_W'(rxb_data) << (int'(lane_sel) * BYTE_W);
   assign merged    = part_q | placed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q        <= '0;
         part_q       <= '0;
         rxw_word     <= '0;
         rxw_valid    <= 1'b0;
         flush_pend_q <= 1'b0;
      end else begin
         if (rxw_valid & rxw_ready) rxw_valid <= 1'b0;
         if (do_flush) begin
            rxw_word     <= part_q;
            rxw_valid    <= 1'b1;
            part_q       <= '0;
            flush_pend_q <= 1'b0;
         end else if (accept) begin
            if (at_last) begin
               rxw_word  <= merged;
               rxw_valid <= 1'b1;
               part_q    <= '0;
               pos_q     <= '0;
            end else begin
               part_q <= merged;
               pos_q  <= pos_q + 1'b1;
            end
         end
         if (xfer_stop && (pos_q != '0) && !flush_pend_q) begin
            flush_pend_q <= 1'b1;
            pos_q        <= '0;
         end
         if (xfer_start) begin
            pos_q <= '0;
            if (!flush_pend_q) part_q <= '0;
         end
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rxw_valid && !rxw_ready |=> rxw_valid && $stable(rxw_word)); // R11
   AST_BLOCK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rxw_valid && !rxw_ready |-> !rxb_ready); // R11
   AST_FLUSH_ZERO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      do_flush |=> rxw_valid && ((rxw_word[WORD_W-1 -: BYTE_W] == '0) ||
                                 (rxw_word[BYTE_W-1:0] == '0))); // R8
endmodule

// File: rtl/i2c_byte_packer.sv
module i2c_byte_packer
   import i2c_pack_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16,
   localparam int LANES = WORD_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_msb_first,
   input  logic              xfer_start,
   input  logic              xfer_stop,
   input  logic [WORD_W-1:0] txw_word,
   input  logic              txw_valid,
   output logic              txw_ready,
   output logic [BYTE_W-1:0] txb_data,
   output logic              txb_valid,
   input  logic              txb_ready,
   output logic              tx_underrun,
   input  logic [BYTE_W-1:0] rxb_data,
   input  logic              rxb_valid,
   output logic              rxb_ready,
   output logic [WORD_W-1:0] rxw_word,
   output logic              rxw_valid,
   input  logic              rxw_ready
);
   if (BYTE_W < 1 || (WORD_W % BYTE_W) != 0) begin : g_bad_width
      $error("i2c_byte_packer: WORD_W must be a whole multiple of BYTE_W");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("i2c_byte_packer: a word needs at least two byte lanes");
   end

   byte_order_e order_q;

   ipk_order_latch u_order (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_msb_first (cfg_msb_first),
      .xfer_start    (xfer_start),
      .order_q       (order_q)
   );

   ipk_tx_split #(.BYTE_W(BYTE_W), .LANES(LANES)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .order_q     (order_q),
      .xfer_start  (xfer_start),
      .xfer_stop   (xfer_stop),
      .txw_word    (txw_word),
      .txw_valid   (txw_valid),
      .txw_ready   (txw_ready),
      .txb_data    (txb_data),
      .txb_valid   (txb_valid),
      .txb_ready   (txb_ready),
      .tx_underrun (tx_underrun)
   );

   ipk_rx_merge #(.BYTE_W(BYTE_W), .LANES(LANES)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .order_q    (order_q),
      .xfer_start (xfer_start),
      .xfer_stop  (xfer_stop),
      .rxb_data   (rxb_data),
      .rxb_valid  (rxb_valid),
      .rxb_ready  (rxb_ready),
      .rxw_word   (rxw_word),
      .rxw_valid  (rxw_valid),
      .rxw_ready  (rxw_ready)
   );
endmodule

// File: tb/test_i2c_byte_packer.sv
module test_i2c_byte_packer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_msb_first = 1'b0, xfer_start = 1'b0, xfer_stop = 1'b0;
   logic [15:0] txw_word = '0;
   logic        txw_valid = 1'b0, txb_ready = 1'b0;
   logic        txw_ready, txb_valid, tx_underrun;
   logic [7:0]  txb_data;
   logic [7:0]  rxb_data = '0;
   logic        rxb_valid = 1'b0, rxw_ready = 1'b0;
   logic        rxb_ready, rxw_valid;
   logic [15:0] rxw_word;

   int errors = 0, checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_byte_packer i_i2c_byte_packer (.*);

   logic [15:0] txq[$];
   logic [7:0]  txexp[$];
   logic [7:0]  rxsrc[$];
   logic [15:0] rxexp[$];
   string       rxtag[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] tx_byte(input logic [15:0] w, input bit big, input int pos);
      return ((pos == 0) == big) ? w[15:8] : w[7:0];
   endfunction

   function automatic logic [15:0] rx_pair(input logic [7:0] b0, input logic [7:0] b1, input bit big);
      return big ? {b0, b1} : {b1, b0};
   endfunction

   function automatic logic [15:0] rx_lone(input logic [7:0] b0, input bit big);
      return big ? {b0, 8'h00} : {8'h00, b0};
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic pulse_start(input bit big);
      cfg_msb_first = big;
      xfer_start = 1'b1;
      tick();
      xfer_start = 1'b0;
   endtask

   task automatic send_rx(input logic [7:0] b);
      bit done = 0;
      rxb_valid = 1'b1;
      rxb_data  = b;
      while (!done) begin
         @(negedge clk);
         done = rxb_ready;
         tick();
      end
      rxb_valid = 1'b0;
   endtask

   task automatic run_xfer(input int nw, input int nb, input bit big);
      bit stopped = 0;
      int sent = 0;
      int guard = 0;
      pulse_start(big);
      for (int i = 0; i < nw; i++) begin
         logic [15:0] w = 16'($urandom);
         txq.push_back(w);
         txexp.push_back(tx_byte(w, big, 0));
         txexp.push_back(tx_byte(w, big, 1));
      end
      for (int i = 0; i < nb; i++) rxsrc.push_back(8'($urandom));
      for (int i = 0; i + 1 < nb; i += 2) begin
         rxexp.push_back(rx_pair(rxsrc[i], rxsrc[i+1], big));
         rxtag.push_back(big ? "R5" : "R4");
      end
      if (nb % 2 == 1) begin
         rxexp.push_back(rx_lone(rxsrc[nb-1], big));
         rxtag.push_back("R8");
      end
      while ((txexp.size() > 0 || rxsrc.size() > 0 || rxexp.size() > 0 || !stopped) && guard < 2000) begin
         bit tx_hs, pop_w, rx_acc, rx_out;
         guard++;
         txw_valid = txq.size() > 0;
         txw_word  = (txq.size() > 0) ? txq[0] : 16'h0;
         txb_ready = (txexp.size() > 0) ? 1'($urandom) : 1'b0;
         rxb_valid = (rxsrc.size() > 0) ? 1'($urandom) : 1'b0;
         rxb_data  = (rxsrc.size() > 0) ? rxsrc[0] : 8'h0;
         rxw_ready = 1'($urandom);
         cfg_msb_first = 1'($urandom);   // R6: noise mid-transfer
         xfer_stop = (!stopped && txexp.size() == 0 && rxsrc.size() == 0);
         @(negedge clk);
         tx_hs  = txb_valid && txb_ready;
         pop_w  = txw_ready;
         rx_acc = rxb_valid && rxb_ready;
         rx_out = rxw_valid && rxw_ready;
         if (tx_hs) begin
            chk(big ? "R3/R6" : "R2/R6", {24'h0, txb_data}, {24'h0, txexp[0]});
            chk("R7", {31'h0, pop_w}, {31'h0, 1'(sent % 2 == 1)});
         end
         if (rx_out) chk({rxtag[0], "/R6"}, {16'h0, rxw_word}, {16'h0, rxexp[0]});
         tick();
         if (xfer_stop) stopped = 1;
         xfer_stop = 1'b0;
         if (tx_hs) begin
            void'(txexp.pop_front());
            sent++;
         end
         if (pop_w && txq.size() > 0) void'(txq.pop_front());
         if (rx_acc) void'(rxsrc.pop_front());
         if (rx_out) begin
            void'(rxexp.pop_front());
            void'(rxtag.pop_front());
         end
      end
      if (guard >= 2000) chk("R7/R11 progress", 32'(guard), 32'(0));
      txw_valid = 1'b0; txb_ready = 1'b0; rxb_valid = 1'b0; rxw_ready = 1'b0;
      tick();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      tick(); tick();
      // R1: reset state
      chk("R1 underrun", {31'h0, tx_underrun}, 32'h0);
      chk("R1 rxw_valid", {31'h0, rxw_valid}, 32'h0);
      rst_n = 1'b1;
      tick();
      // R1: no START yet, request big-endian but little stays in force
      cfg_msb_first = 1'b1;
      txw_valid = 1'b1; txw_word = 16'hA1B2; txb_ready = 1'b1;
      @(negedge clk);
      chk("R1 first byte", {24'h0, txb_data}, 32'hB2);
      tick();
      @(negedge clk);
      chk("R1 second byte", {24'h0, txb_data}, 32'hA1);
      chk("R7 pop on second", {31'h0, txw_ready}, 32'h1);
      tick();
      txw_valid = 1'b0; txb_ready = 1'b0;

      // R10: underrun
      pulse_start(1'b0);
      txb_ready = 1'b1;
      @(negedge clk);
      chk("R10 no valid", {31'h0, txb_valid}, 32'h0);
      tick();
      txb_ready = 1'b0;
      chk("R10 flag set", {31'h0, tx_underrun}, 32'h1);
      tick(); tick();
      chk("R10 flag sticky", {31'h0, tx_underrun}, 32'h1);
      pulse_start(1'b0);
      chk("R10 flag cleared", {31'h0, tx_underrun}, 32'h0);

      // R12: stop after one byte of a word
      txw_valid = 1'b1; txw_word = 16'h1234; txb_ready = 1'b1;
      @(negedge clk);
      chk("R12 first byte", {24'h0, txb_data}, 32'h34);
      chk("R7 no early pop", {31'h0, txw_ready}, 32'h0);
      tick();
      txb_ready = 1'b0; xfer_stop = 1'b1;
      @(negedge clk);
      chk("R12 flush pop", {31'h0, txw_ready}, 32'h1);
      tick();
      xfer_stop = 1'b0; txw_word = 16'h5678; txb_ready = 1'b1;
      @(negedge clk);
      chk("R12 restart lane", {24'h0, txb_data}, 32'h78);
      tick();
      @(negedge clk);
      chk("R12 second lane", {24'h0, txb_data}, 32'h56);
      tick();
      txw_valid = 1'b0; txb_ready = 1'b0;

      // R9: START drops a lone byte and resets position
      rxw_ready = 1'b1;
      pulse_start(1'b0);
      send_rx(8'h11);
      pulse_start(1'b0);
      send_rx(8'h22);
      send_rx(8'h33);
      chk("R9 realigned word", {15'h0, rxw_valid, rxw_word}, {15'h0, 1'b1, 16'h3322});
      tick();
      xfer_stop = 1'b1; tick(); xfer_stop = 1'b0;
      tick();
      chk("R9 no flush", {31'h0, rxw_valid}, 32'h0);

      // R11: back-pressure on the word side
      rxw_ready = 1'b0;
      pulse_start(1'b1);
      send_rx(8'hAA);
      send_rx(8'hBB);
      rxb_valid = 1'b1; rxb_data = 8'hCC;
      tick();
      @(negedge clk);
      chk("R11 blocked", {31'h0, rxb_ready}, 32'h0);
      chk("R5 held word", {16'h0, rxw_word}, 32'hAABB);
      tick();
      chk("R11 word stable", {15'h0, rxw_valid, rxw_word}, {15'h0, 1'b1, 16'hAABB});
      rxw_ready = 1'b1;
      tick();
      rxb_valid = 1'b0;
      rxw_ready = 1'b0;
      send_rx(8'hDD);
      chk("R5 next word", {16'h0, rxw_word}, 32'hCCDD);
      rxw_ready = 1'b1; tick(); rxw_ready = 1'b0;

      // R8: flush of a lone big-endian byte
      pulse_start(1'b1);
      send_rx(8'h5A);
      xfer_stop = 1'b1; tick(); xfer_stop = 1'b0;
      tick();
      chk("R8 zero fill", {15'h0, rxw_valid, rxw_word}, {15'h0, 1'b1, 16'h5A00});
      rxw_ready = 1'b1; tick(); rxw_ready = 1'b0;

      // random transfers: R2 R3 R4 R5 R6 R7 R8
      for (int t = 0; t < 40; t++) begin
         run_xfer(int'($urandom % 7), int'($urandom % 10), 1'($urandom));
      end
      chk("R7 tx queue drained", 32'(txq.size()), 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule